// File: doc/BRIEF.md
# Packet FIFO with Mark, Restore and Deadlock Detection

This block stores 32-bit words for a DMA-driven packet interface. One side pushes words and brackets each packet with three controls. Mark records a write position. Restore rewinds the write position to the last mark, so a partly written packet can be dropped or written again. Commit releases everything written so far to the consumer. The consumer pops committed words in order. Only committed words can be popped, so a packet that alone fills the whole storage can never finish. The block reports that case as a deadlock: a flag that stays set, together with an error interrupt.

An elaboration parameter sets the kind of FIFO.
- In a read FIFO (kind 0), hardware fills the FIFO and software drains it. The status word then reports occupancy and an empty flag.
- In a write FIFO (kind 1), software fills the FIFO and hardware drains it. The status word then reports vacancy and a full flag.

A small register port gives the status word at byte offset 4. At byte offset 0 it gives an identification word on reads and a clear command on writes. Writing the clear key empties the FIFO and removes the deadlock.

Top module: `pkt_fifo`

## Requirements
- R1: With KIND=0, status bits 15:0 give the number of committed words not yet popped. With KIND=1, they give DEPTH minus all stored words, committed or not.
- R2: Status bit 31 is set when no committed word is present (KIND=0), or when the stored words equal DEPTH (KIND=1).
- R3: Status bit 30 is set when exactly one committed word is present (KIND=0), or when exactly one free word remains (KIND=1).
- R4: A pushed word can be popped only after a commit. `pop_avail` is high exactly when a committed word is present. A pop while none is present has no effect.
- R5: Mark records the write position, including a push made in the same cycle. Restore returns the write position to the recorded one, which drops the words written after it. While restore is high, push, mark and commit in the same cycle are ignored.
- R6: Commit releases every stored word, including a push made in the same cycle. Commit also moves the mark to the new write position.
- R7: A push while the stored words equal DEPTH is ignored.
- R8: When the stored words equal DEPTH and none of them is committed, status bit 29 and `err_irq` are set in the same cycle that the count shows it. Both stay set through restores, pops and pushes until a clear.
- R9: Writing 0x0000000A at byte offset 0 discards all words, resets the mark, and clears bit 29 and `err_irq` from the next cycle on. A write of any other value, or any write at offset 4, changes nothing.
- R10: A read at offset 0 returns the ID parameter in bits 31:24, KIND in bit 16, log2(DEPTH) in bits 7:0, and zero in the other bits. At offset 4, bits 28:16 read as zero. Only bit 2 of `reg_addr` selects the register.
- R11: Words are popped in the order they were pushed. After a restore, words pushed again take the place of the dropped ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Write one word into the FIFO |
| push_data | input | DW | Word to write |
| mark | input | 1 | Record the current write position |
| restore | input | 1 | Rewind the write position to the mark |
| commit | input | 1 | Release all stored words to the consumer |
| pop | input | 1 | Remove the head word |
| pop_data | output | DW | Head word, valid while pop_avail is high |
| pop_avail | output | 1 | A committed word is present |
| reg_addr | input | 3 | Byte offset of the register access |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| err_irq | output | 1 | Error interrupt, high while deadlocked |

## Verification
The hardest state to reach is the deadlock.
- The stimulus pushes exactly DEPTH words with no commit, so the FIFO is full and empty at once.
- It then restores the write position to empty storage, pushes again and pops. The flag must hold through all of these.
- It writes a wrong key at offset 0, then the right key at offset 4. Neither may clear the flag.
- Only the correct key at offset 0 may clear it.

A read instance and a write instance share the same stimulus. Each action is therefore checked against both status encodings: occupancy and empty on one, vacancy and full on the other.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;

   localparam logic [31:0] CLEAR_KEY  = 32'h0000_000A;
   localparam int          KIND_READ  = 0;
   localparam int          KIND_WRITE = 1;

   // status word at byte offset 4
   typedef struct packed {
      logic        edge_flag;   // empty (read kind) or full (write kind)
      logic        almost;
      logic        dead;
      logic [12:0] rsvd;
      logic [15:0] count;
   } status_t;

   // identification word at byte offset 0
   typedef struct packed {
      logic [7:0] id;
      logic [6:0] rsvd_h;
      logic       kind;
      logic [7:0] rsvd_m;
      logic [7:0] log_depth;
   } info_t;

endpackage

// File: rtl/pkt_fifo_ptrs.sv
module pkt_fifo_ptrs #(
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic          mark,
   input  logic          restore,
   input  logic          commit,
   input  logic          pop,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic [PW-1:0] used,
   output logic [PW-1:0] committed,
   output logic          dead
);

   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
   localparam logic [PW-1:0] ONE      = PW'(1);

   logic [PW-1:0] wr_q, cm_q, mk_q, rd_q;
   logic [PW-1:0] wr_n, cm_n, mk_n, rd_n;
   logic          dead_q, dead_n;
   logic          push_ok, pop_ok;

   assign used      = wr_q - rd_q;
   assign committed = cm_q - rd_q;

   assign push_ok = push && !restore && (used != FULL_CNT);
   assign pop_ok  = pop && (cm_q != rd_q);

   always_comb begin
      wr_n = wr_q;
      cm_n = cm_q;
      mk_n = mk_q;
      rd_n = rd_q;
      if (restore) begin
         wr_n = mk_q;
      end else begin
         if (push_ok) wr_n = wr_q + ONE;
         if (mark)    mk_n = wr_n;
         if (commit) begin
            cm_n = wr_n;
            mk_n = wr_n;
         end
      end
      if (pop_ok) rd_n = rd_q + ONE;
      dead_n = dead_q || (((wr_n - rd_n) == FULL_CNT) && (cm_n == rd_n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= '0;
         cm_q   <= '0;
         mk_q   <= '0;
         rd_q   <= '0;
         dead_q <= 1'b0;
      end else if (clear) begin
         wr_q   <= '0;
         cm_q   <= '0;
         mk_q   <= '0;
         rd_q   <= '0;
         dead_q <= 1'b0;
      end else begin
         wr_q   <= wr_n;
         cm_q   <= cm_n;
         mk_q   <= mk_n;
         rd_q   <= rd_n;
         dead_q <= dead_n;
      end
   end

   assign wr_en   = push_ok && !clear;
   assign wr_addr = wr_q[AW-1:0];
   assign rd_addr = rd_q[AW-1:0];
   assign dead    = dead_q;

endmodule

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
   parameter int DEPTH = 16,
   parameter int DW    = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] cells [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == AW'(g))) cells[g] <= wr_data;
      end
   end

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/pkt_fifo_regs.sv
module pkt_fifo_regs
   import pkt_fifo_pkg::*;
#(
   parameter int         KIND    = 0,
   parameter int         DEPTH   = 16,
   parameter int         AW      = $clog2(DEPTH),
   parameter int         PW      = AW + 1,
   parameter logic [7:0] INFO_ID = 8'h5A
) (
   input  logic [2:0]    reg_addr,
   input  logic          reg_wen,
   input  logic [31:0]   reg_wdata,
   input  logic [PW-1:0] used,
   input  logic [PW-1:0] committed,
   input  logic          dead,
   output logic [31:0]   reg_rdata,
   output logic          clear
);

   localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
   localparam logic [PW-1:0] ONE      = PW'(1);

   logic [15:0] cnt_w;
   logic        edge_w, almost_w;
   status_t     stat;
   info_t       info;

   if (KIND == KIND_READ) begin : g_read
      assign cnt_w    = 16'(committed);
      assign edge_w   = (committed == '0);
      assign almost_w = (committed == ONE);
   end else begin : g_write
      logic [PW-1:0] vac;
      assign vac      = FULL_CNT - used;
      assign cnt_w    = 16'(vac);
      assign edge_w   = (used == FULL_CNT);
      assign almost_w = (vac == ONE);
   end

   always_comb begin
      stat           = '0;
      stat.edge_flag = edge_w;
      stat.almost    = almost_w;
      stat.dead      = dead;
      stat.count     = cnt_w;
      info           = '0;
      info.id        = INFO_ID;
      info.kind      = (KIND == KIND_WRITE);
      info.log_depth = 8'(AW);
   end

   assign reg_rdata = reg_addr[2] ? stat : info;
   assign clear     = reg_wen && !reg_addr[2] && (reg_wdata == CLEAR_KEY);

endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo
   import pkt_fifo_pkg::*;
#(
   parameter int         KIND    = 0,
   parameter int         DEPTH   = 16,
   parameter int         DW      = 32,
   parameter logic [7:0] INFO_ID = 8'h5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          mark,
   input  logic          restore,
   input  logic          commit,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic          pop_avail,
   input  logic [2:0]    reg_addr,
   input  logic          reg_wen,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          err_irq
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (KIND != KIND_READ && KIND != KIND_WRITE) begin : g_bad_kind
      $error("pkt_fifo: KIND must be 0 or 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pkt_fifo: DEPTH must be a power of two, at least 2");
   end
   if (DEPTH > 32768) begin : g_big_depth
      $error("pkt_fifo: DEPTH must fit the 16-bit count field");
   end
   if (DW < 1) begin : g_bad_dw
      $error("pkt_fifo: DW must be positive");
   end

   logic          clear;
   logic          wr_en;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [PW-1:0] used_w, committed_w;
   logic          dead_w;

   pkt_fifo_ptrs #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptrs (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .push      (push),
      .mark      (mark),
      .restore   (restore),
      .commit    (commit),
      .pop       (pop),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr),
      .used      (used_w),
      .committed (committed_w),
      .dead      (dead_w)
   );

   pkt_fifo_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (push_data),
      .rd_addr (rd_addr),
      .rd_data (pop_data)
   );

   pkt_fifo_regs #(
      .KIND(KIND), .DEPTH(DEPTH), .AW(AW), .PW(PW), .INFO_ID(INFO_ID)
   ) u_regs (
      .reg_addr  (reg_addr),
      .reg_wen   (reg_wen),
      .reg_wdata (reg_wdata),
      .used      (used_w),
      .committed (committed_w),
      .dead      (dead_w),
      .reg_rdata (reg_rdata),
      .clear     (clear)
   );

   assign pop_avail = (committed_w != '0);
   assign err_irq   = dead_w;

endmodule

// File: rtl/pkt_fifo_chk.sv
module pkt_fifo_chk
   import pkt_fifo_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int PW    = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pop,
   input logic          commit,
   input logic          pop_avail,
   input logic [2:0]    reg_addr,
   input logic          reg_wen,
   input logic [31:0]   reg_wdata,
   input logic [31:0]   reg_rdata,
   input logic          err_irq,
   input logic [PW-1:0] used,
   input logic [PW-1:0] committed
);

   logic clr;
   assign clr = reg_wen && !reg_addr[2] && (reg_wdata == CLEAR_KEY);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      used <= PW'(DEPTH));

   p_commit_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      committed <= used);

   p_avail_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pop_avail == (committed != '0));

   p_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && committed == '0 && !commit && !clr) |=> (committed == '0));

   p_dead_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_irq && !clr) |=> err_irq);

   p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr[2] |-> (reg_rdata[29] == err_irq));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!err_irq && used == '0));

   p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_addr[2] |-> (reg_rdata[28:16] == 13'd0));

endmodule

bind pkt_fifo pkt_fifo_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pop       (pop),
   .commit    (commit),
   .pop_avail (pop_avail),
   .reg_addr  (reg_addr),
   .reg_wen   (reg_wen),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .err_irq   (err_irq),
   .used      (used_w),
   .committed (committed_w)
);

// File: tb/sim_pkt_fifo.sv
`timescale 1ns/1ps
module sim_pkt_fifo;

   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push = 0, mark = 0, restore = 0, commit = 0, pop = 0;
   logic [31:0] push_data = '0;
   logic [2:0]  reg_addr = 3'd4;
   logic        reg_wen = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] pd0, pd1, rd0, rd1;
   logic        av0, av1, irq0, irq1;

   int n_chk = 0, n_fail = 0;

   logic [31:0] exp_q[$];
   logic [31:0] pend[$];
   int          mk = 0;
   bit          dead_m = 0;

   always #5 clk = ~clk;

   pkt_fifo #(.KIND(0), .DEPTH(D)) u0 (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .mark(mark), .restore(restore), .commit(commit), .pop(pop),
      .pop_data(pd0), .pop_avail(av0), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(rd0), .err_irq(irq0));

   pkt_fifo #(.KIND(1), .DEPTH(D)) u1 (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .mark(mark), .restore(restore), .commit(commit), .pop(pop),
      .pop_data(pd1), .pop_avail(av1), .reg_addr(reg_addr), .reg_wen(reg_wen),
      .reg_wdata(reg_wdata), .reg_rdata(rd1), .err_irq(irq1));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_stat(int kind);
      int c = exp_q.size();
      int s = exp_q.size() + pend.size();
      logic [31:0] w = '0;
      w[29] = dead_m;
      if (kind == 0) begin
         w[31] = (c == 0); w[30] = (c == 1); w[15:0] = 16'(c);
      end else begin
         w[31] = (s == D); w[30] = (D - s == 1); w[15:0] = 16'(D - s);
      end
      return w;
   endfunction

   task automatic upd_dead();
      if (exp_q.size() == 0 && pend.size() == D) dead_m = 1;
   endtask

   task automatic stat(string req);
      reg_addr = 3'd4;
      #1;
      check({req, " read-kind status"}, rd0, exp_stat(0));
      check({req, " write-kind status"}, rd1, exp_stat(1));
      check({req, " irq"}, {31'd0, irq0}, {31'd0, dead_m});
   endtask

   // driver: one cycle of producer activity, with the scoreboard updated
   task automatic op(bit p, logic [31:0] d, bit m, bit r, bit c);
      push = p; push_data = d; mark = m; restore = r; commit = c;
      @(posedge clk); #1;
      push = 0; mark = 0; restore = 0; commit = 0;
      if (r) begin
         while (pend.size() > mk) void'(pend.pop_back());
      end else begin
         if (p && (exp_q.size() + pend.size() < D)) pend.push_back(d);
         if (m) mk = pend.size();
         if (c) begin
            foreach (pend[i]) exp_q.push_back(pend[i]);
            pend = {};
            mk = 0;
         end
      end
      upd_dead();
   endtask

   // monitor side: compare the head word against the scoreboard, then pop
   task automatic pop_one(string req);
      check({req, " avail"}, {31'd0, av0}, {31'd0, exp_q.size() != 0});
      if (exp_q.size() != 0) begin
         check({req, " data u0"}, pd0, exp_q[0]);
         check({req, " data u1"}, pd1, exp_q[0]);
         void'(exp_q.pop_front());
      end
      pop = 1;
      @(posedge clk); #1;
      pop = 0;
   endtask

   task automatic wreg(logic [2:0] a, logic [31:0] d);
      reg_addr = a; reg_wdata = d; reg_wen = 1;
      @(posedge clk); #1;
      reg_wen = 0; reg_addr = 3'd4;
      if (!a[2] && d == 32'h0000_000A) begin
         exp_q = {}; pend = {}; mk = 0; dead_m = 0;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(posedge clk); #1;

      // reset state, R1 R2, info words R10
      stat("R1 R2 reset");
      reg_addr = 3'd0; #1;
      check("R10 info u0", rd0, 32'h5A00_0003);
      check("R10 info u1", rd1, 32'h5A01_0003);
      reg_addr = 3'd1; #1;
      check("R10 low addr bits ignored", rd1, 32'h5A01_0003);
      reg_addr = 3'd6; #1;
      check("R10 offset 6 decodes as 4", rd0, exp_stat(0));

      // uncommitted words are hidden, R4
      op(1, 32'h1111_0001, 0, 0, 0);
      op(1, 32'h1111_0002, 0, 0, 0);
      op(1, 32'h1111_0003, 0, 0, 0);
      stat("R4 before commit");
      check("R4 avail before commit", {31'd0, av0}, 32'd0);
      op(0, 0, 0, 0, 1);
      stat("R1 after commit");

      // order and almost-empty, R11 R3
      pop_one("R11 first");
      pop_one("R11 second");
      stat("R3 one committed word");

      // mark, push, restore, then push again, R5 R11
      op(0, 0, 1, 0, 0);
      op(1, 32'hBAD0_0001, 0, 0, 0);
      op(1, 32'hBAD0_0002, 0, 0, 0);
      stat("R5 before restore");
      op(0, 0, 0, 1, 0);
      stat("R5 after restore");
      op(1, 32'h2222_0001, 0, 0, 0);
      op(1, 32'h2222_0002, 0, 0, 1);      // R6 push and commit together
      stat("R6 same-cycle commit");
      // restore with push in the same cycle: push ignored, R5
      op(1, 32'hDEAD_0000, 0, 1, 0);
      stat("R5 push ignored under restore");
      pop_one("R11 after restore a");
      pop_one("R11 after restore b");
      pop_one("R11 after restore c");
      // pop while empty has no effect, R4
      pop_one("R4 pop when empty");
      stat("R4 empty pop ignored");
      op(1, 32'h3333_0001, 0, 0, 1);
      pop_one("R4 head after empty pop");

      // fill to almost-full and full, overflow push, R3 R2 R7
      for (int i = 0; i < D - 1; i++) op(1, 32'h4444_0000 + i, 0, 0, 0);
      op(0, 0, 0, 0, 1);
      stat("R3 one free word");
      op(1, 32'h4444_00FF, 0, 0, 1);
      stat("R2 full");
      op(1, 32'hBAD0_00FF, 0, 0, 1);
      stat("R7 push while full ignored");
      // R9 wrong key and offset 4 writes ignored while holding data
      wreg(3'd0, 32'h0000_000B);
      wreg(3'd4, 32'h0000_000A);
      stat("R9 ignored writes");
      for (int i = 0; i < D; i++) pop_one("R7 R11 drain");
      stat("R7 drained");

      // deadlock, R8
      for (int i = 0; i < D; i++) op(1, 32'h5555_0000 + i, 0, 0, 0);
      stat("R8 deadlock set");
      check("R8 irq write kind", {31'd0, irq1}, 32'd1);
      op(0, 0, 0, 1, 0);
      stat("R8 sticky after restore");
      op(1, 32'h6666_0001, 0, 0, 1);
      pop_one("R8 pop while dead");
      stat("R8 sticky after pop");
      wreg(3'd0, 32'h0000_0005);
      wreg(3'd4, 32'h0000_000A);
      stat("R9 wrong key keeps deadlock");
      op(1, 32'h7777_0001, 0, 0, 1);
      wreg(3'd0, 32'h0000_000A);
      stat("R9 clear");
      check("R9 avail after clear", {31'd0, av0}, 32'd0);
      op(1, 32'h8888_0001, 0, 0, 0);
      op(0, 0, 0, 1, 0);
      stat("R9 mark reset by clear");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule